// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block gathers five interrupt sources for a small CPU core and turns them into a single interrupt request with a fixed program-memory vector. The sources are two active-low external pins, a counter/timer overflow flag, a bus-watchdog timer flag and a serial-bus flag. Each source has its own enable bit, and one global enable gates all of them. There is one interrupt level only. The order among sources is hard-wired, and there is no priority register.

Requests are sampled on a machine-cycle strobe. When the CPU is not already servicing an interrupt, the highest-priority enabled source is latched. The block then raises `irq` and holds its vector steady until the CPU acknowledges it. An acknowledge moves the block into service, and no further interrupt is taken until a return strobe arrives. Each external pin can be set to low-level or falling-edge sensing. A combinational wake output tells the power controller that an enabled request is pending, so that idle mode can end.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `irq` is 0, `vec` is 0x000, `in_svc` is 0 and `wake` is 0 when no source is active.
- R2: When several enabled requests are pending at the same time, the winner is chosen in this order, highest first: external pin 0, timer flag, external pin 1, watchdog flag, serial-bus flag.
- R3: The latched vector is 0x003 for external pin 0, 0x00B for the timer, 0x013 for external pin 1, 0x01B for the watchdog and 0x023 for the serial bus.
- R4: A source takes part only if its bit in `src_en` is 1 and `glob_en` is 1. The bits of `src_en` are: bit 0 external pin 0, bit 1 timer, bit 2 external pin 1, bit 3 watchdog, bit 4 serial bus.
- R5: `wake` is 1 in the same cycle that any enabled source is pending, whether or not a routine is in service.
- R6: A request is latched only on a clock edge where `cyc_stb` is 1. `irq` rises in the cycle after that edge.
- R7: While `irq` is 1 and `ack` has not been given, `irq` and `vec` stay unchanged, even if the requests change or a higher source arrives.
- R8: One `ack` while `irq` is 1 clears `irq` and sets `in_svc` on the next edge. While `in_svc` is 1, no new request is latched. A `reti` pulse clears `in_svc`, after which the next strobe takes a pending request.
- R9: In level mode (`extN_edge` = 0), an external pin requests whenever it is low. A pin still held low is taken again after `reti`.
- R10: In edge mode (`extN_edge` = 1), a high-to-low change seen between two strobes sets a request latch. The latched request is taken on the following strobe and cleared by its `ack`. A pin that stays low does not request again.
- R11: An edge-mode request stays latched even if the pin returns high before it is serviced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_stb | input | 1 | Machine-cycle sampling strobe |
| ext0_n | input | 1 | External pin 0, active low |
| ext1_n | input | 1 | External pin 1, active low |
| ext0_edge | input | 1 | 1: falling-edge sensing for pin 0; 0: low level |
| ext1_edge | input | 1 | 1: falling-edge sensing for pin 1; 0: low level |
| tmr_flag | input | 1 | Counter/timer overflow flag |
| wdt_flag | input | 1 | Bus-watchdog timer flag |
| bus_flag | input | 1 | Serial-bus flag |
| src_en | input | 5 | Per-source enables, bit map as in R4 |
| glob_en | input | 1 | Global interrupt enable |
| ack | input | 1 | CPU accepts the presented vector |
| reti | input | 1 | Return-from-interrupt strobe |
| irq | output | 1 | Interrupt request to the CPU |
| vec | output | 11 | Latched vector address |
| in_svc | output | 1 | Service routine in progress |
| wake | output | 1 | Enabled request pending (idle exit) |

## Verification
`wake` is combinational, so it is checked one time step after the inputs change. `irq` and `vec` change on the edge that carries the strobe, so they are checked just after that edge. A falling edge on an external pin needs two strobes: the first sets the latch and the second takes the request. `in_svc` and the clearing of `irq` follow one edge after `ack`. Every check is made a fixed 2 ns after the edge that should produce it, and inputs change only at that point.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int VW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_stb,
  input  logic          ext0_n,
  input  logic          ext1_n,
  input  logic          ext0_edge,
  input  logic          ext1_edge,
  input  logic          tmr_flag,
  input  logic          wdt_flag,
  input  logic          bus_flag,
  input  logic [4:0]    src_en,
  input  logic          glob_en,
  input  logic          ack,
  input  logic          reti,
  output logic          irq,
  output logic [VW-1:0] vec,
  output logic          in_svc,
  output logic          wake
);
  localparam int NSRC = 5;
  localparam int IW   = $clog2(NSRC);

  logic [1:0]      pin_q, edge_lat;
  logic [NSRC-1:0] req, masked;
  logic [IW-1:0]   pick, win;
  logic            irq_q, svc_q;
  logic [VW-1:0]   vec_q;

  assign req = {bus_flag, wdt_flag,
                ext1_edge ? edge_lat[1] : ~ext1_n,
                tmr_flag,
                ext0_edge ? edge_lat[0] : ~ext0_n};
  assign masked = req & src_en & {NSRC{glob_en}};
  assign wake   = |masked;

  always_comb begin
    pick = '0;
    for (int i = NSRC-1; i >= 0; i--)
      if (masked[i]) pick = IW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_q    <= 2'b11;
      edge_lat <= 2'b00;
      irq_q    <= 1'b0;
      svc_q    <= 1'b0;
      win      <= '0;
      vec_q    <= '0;
    end else begin
      if (irq_q && ack) begin
        irq_q <= 1'b0;
        svc_q <= 1'b1;
        if (win == IW'(0)) edge_lat[0] <= 1'b0;
        if (win == IW'(2)) edge_lat[1] <= 1'b0;
      end
      if (svc_q && reti) svc_q <= 1'b0;
      if (!ext0_edge) edge_lat[0] <= 1'b0;
      if (!ext1_edge) edge_lat[1] <= 1'b0;
      if (cyc_stb) begin
        pin_q <= {ext1_n, ext0_n};
        if (ext0_edge && pin_q[0] && !ext0_n) edge_lat[0] <= 1'b1;
        if (ext1_edge && pin_q[1] && !ext1_n) edge_lat[1] <= 1'b1;
        if (!irq_q && !svc_q && wake) begin
          irq_q <= 1'b1;
          win   <= pick;
          vec_q <= VW'({pick, 3'b011});
        end
      end
    end
  end

  assign irq    = irq_q;
  assign vec    = vec_q;
  assign in_svc = svc_q;

  a_r7_vec_held: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ack) |=> (irq && $stable(vec)));
  a_r8_svc_blocks_irq: assert property (@(posedge clk) disable iff (!rst_n)
    in_svc |-> !irq);
  a_r8_ack_enters_svc: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && ack) |=> (in_svc && !irq));
  a_r6_rise_on_stb: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(cyc_stb));
  a_r6_take_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_stb && wake && !irq && !in_svc) |=> irq);
  a_r3_vec_legal: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (vec == VW'(3) || vec == VW'(11) || vec == VW'(19) ||
             vec == VW'(27) || vec == VW'(35)));
  a_r4_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en |-> !wake);
endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, cyc_stb = 1'b0;
  logic ext0_n = 1'b1, ext1_n = 1'b1, ext0_edge = 1'b0, ext1_edge = 1'b0;
  logic tmr_flag = 1'b0, wdt_flag = 1'b0, bus_flag = 1'b0;
  logic [4:0] src_en = '0;
  logic glob_en = 1'b0, ack = 1'b0, reti = 1'b0;
  logic irq, in_svc, wake;
  logic [10:0] vec;
  int nchk = 0, nfail = 0;

  always #4 clk = ~clk;

  prio_irq_ctrl u0 (.clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .ext0_n(ext0_n),
    .ext1_n(ext1_n), .ext0_edge(ext0_edge), .ext1_edge(ext1_edge), .tmr_flag(tmr_flag),
    .wdt_flag(wdt_flag), .bus_flag(bus_flag), .src_en(src_en), .glob_en(glob_en),
    .ack(ack), .reti(reti), .irq(irq), .vec(vec), .in_svc(in_svc), .wake(wake));

  typedef struct packed {
    logic [4:0]  rq;
    logic [4:0]  en;
    logic        g;
    logic        xi;
    logic [10:0] xv;
  } row_t;

  localparam row_t TBL [13] = '{
    '{5'b11111, 5'b11111, 1'b1, 1'b1, 11'h003},
    '{5'b11110, 5'b11111, 1'b1, 1'b1, 11'h00B},
    '{5'b11100, 5'b11111, 1'b1, 1'b1, 11'h013},
    '{5'b11000, 5'b11111, 1'b1, 1'b1, 11'h01B},
    '{5'b10000, 5'b11111, 1'b1, 1'b1, 11'h023},
    '{5'b11111, 5'b11110, 1'b1, 1'b1, 11'h00B},
    '{5'b11111, 5'b00000, 1'b1, 1'b0, 11'h000},
    '{5'b11111, 5'b11111, 1'b0, 1'b0, 11'h000},
    '{5'b10100, 5'b10100, 1'b1, 1'b1, 11'h013},
    '{5'b01010, 5'b11111, 1'b1, 1'b1, 11'h00B},
    '{5'b10001, 5'b10000, 1'b1, 1'b1, 11'h023},
    '{5'b01000, 5'b01000, 1'b1, 1'b1, 11'h01B},
    '{5'b00000, 5'b11111, 1'b1, 1'b0, 11'h000}
  };

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic cyc(input logic s);
    cyc_stb = s;
    @(posedge clk);
    #2;
    cyc_stb = 1'b0;
  endtask

  task automatic pulse_ack;
    ack = 1'b1; cyc(1'b0); ack = 1'b0;
  endtask

  task automatic pulse_reti;
    reti = 1'b1; cyc(1'b0); reti = 1'b0;
  endtask

  task automatic drive(input logic [4:0] rq);
    ext0_n = ~rq[0]; tmr_flag = rq[1]; ext1_n = ~rq[2]; wdt_flag = rq[3]; bus_flag = rq[4];
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cyc(1'b0); cyc(1'b0);
    rst_n = 1'b1;
    cyc(1'b0);
    chk("R1 irq", irq, 0); chk("R1 vec", vec, 11'h000);
    chk("R1 in_svc", in_svc, 0); chk("R1 wake", wake, 0);

    for (int k = 0; k < 13; k++) begin
      drive(TBL[k].rq); src_en = TBL[k].en; glob_en = TBL[k].g;
      #1;
      chk("R5/R4 wake", wake, TBL[k].xi);
      cyc(1'b1);
      chk("R2/R4 irq", irq, TBL[k].xi);
      if (TBL[k].xi) begin
        chk("R2/R3 vec", vec, TBL[k].xv);
        pulse_ack(); pulse_reti();
      end
      drive(5'b0);
    end

    glob_en = 1'b1; src_en = 5'b11111;
    tmr_flag = 1'b1;
    cyc(1'b0); cyc(1'b0);
    chk("R6 no strobe irq", irq, 0); chk("R5 wake", wake, 1);
    cyc(1'b1);
    chk("R6 strobe irq", irq, 1); chk("R6 vec", vec, 11'h00B);
    pulse_ack(); pulse_reti(); tmr_flag = 1'b0;

    bus_flag = 1'b1; cyc(1'b1);
    chk("R7 bus vec", vec, 11'h023);
    bus_flag = 1'b0; ext0_n = 1'b0; cyc(1'b1); cyc(1'b1);
    chk("R7 irq held", irq, 1); chk("R7 vec held", vec, 11'h023);

    pulse_ack();
    chk("R8 irq cleared", irq, 0); chk("R8 in_svc", in_svc, 1);
    cyc(1'b1); cyc(1'b1);
    chk("R8 blocked irq", irq, 0); chk("R5 wake in svc", wake, 1);
    pulse_reti();
    chk("R8 in_svc cleared", in_svc, 0);
    cyc(1'b1);
    chk("R8 retaken irq", irq, 1); chk("R9 level vec", vec, 11'h003);
    pulse_ack(); pulse_reti();
    cyc(1'b1);
    chk("R9 level retake", irq, 1);
    pulse_ack(); pulse_reti();
    ext0_n = 1'b1;

    ext0_edge = 1'b1; src_en = 5'b00001;
    cyc(1'b1);
    ext0_n = 1'b0; cyc(1'b1);
    chk("R10 latch stage irq", irq, 0);
    cyc(1'b1);
    chk("R10 edge irq", irq, 1); chk("R10 edge vec", vec, 11'h003);
    pulse_ack(); pulse_reti();
    cyc(1'b1); cyc(1'b1);
    chk("R10 no retrigger", irq, 0); chk("R10 wake off", wake, 0);

    ext0_n = 1'b1; cyc(1'b1);
    ext0_n = 1'b0; cyc(1'b1);
    ext0_n = 1'b1; cyc(1'b0);
    chk("R11 wake latched", wake, 1);
    cyc(1'b1);
    chk("R11 latched irq", irq, 1); chk("R11 vec", vec, 11'h003);
    pulse_ack(); pulse_reti();
    chk("R11 cleared by ack", wake, 0);

    finish_run();
  end
endmodule